// File: doc/BRIEF.md
# Aligned Load Word-Lane Extractor

This data-path unit sits between a processor's load port and its register file. It does two things. It clears the low address bits of a load address so that every memory access is aligned to the native word. It also pulls a single byte or half-word out of a word that has already been loaded, and places it zero-extended in the destination.

The lane is not chosen by the load itself. It is chosen by the low bits of a separate address operand, usually the same address register that fed the load. Lanes are numbered little-endian: lane 0 is the least significant byte of the word.

The default configuration is a 32-bit word. A parameter selects a 16-bit word, and in that variant only byte extraction exists. Another parameter chooses whether the two outputs are registered (one cycle of latency, cleared by reset) or purely combinational.

Top module: `lx_load_extract`

## Requirements
- R1: With the registered output option (the default), a clock edge with `rst_n` low clears both `bus_addr` and `result` to zero, whatever the inputs are.
- R2: `bus_addr` equals `addr_in` with its lane-select bits forced to zero. These are bits 1:0 for a 32-bit word and bit 0 for a 16-bit word. All higher bits pass through unchanged.
- R3: When `op_sel` = 0 (byte extract), lane k of `word_in`, meaning bits 8k+7:8k, goes to `result[7:0]`. Here k is `addr_in[1:0]` for a 32-bit word. For example, word 0x48534946 with address bits 10 gives 0x53.
- R4: A byte extract drives every bit of `result` above bit 7 to zero.
- R5: When `op_sel` = 1 (half-word extract, 32-bit word only), `addr_in[1]` = 0 selects bits 15:0 and `addr_in[1]` = 1 selects bits 31:16. `addr_in[0]` has no effect. Bits 31:16 of `result` are zero.
- R6: With the registered option, the outputs show the inputs sampled at the previous rising edge. A change of inputs between edges leaves the outputs unchanged.
- R7: In the 16-bit variant, `addr_in[0]` picks the byte lane, `op_sel` has no effect, and the result is always the zero-extended byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | DATA_W | Loaded word to extract from |
| addr_in | input | ADDR_W | Address operand; its low bits select the lane |
| op_sel | input | 1 | 0 = byte extract, 1 = half-word extract (ignored when DATA_W = 16) |
| bus_addr | output | ADDR_W | Word-aligned address for the memory access |
| result | output | DATA_W | Zero-extended extracted byte or half-word |

## Verification
Fixed vectors use a word with four distinct bytes at every lane. Any swapped or reversed lane order therefore produces a visibly wrong byte, and the same word reproduces the 0x53 case.

All-ones words and addresses show whether zero-extension and address masking clear exactly the right bits. A word with only its top bit set shows whether a half-word is selected by bit 1 instead of bit 0.

A random sweep over every lane and both operations separates correct mux selection from agreement that only holds by chance. A 16-bit instance shows that the operation select has no effect there.

Changing the inputs between edges, and asserting reset while the inputs are non-zero, separate registered behaviour from pass-through behaviour.

// File: rtl/lx_pkg.sv
// Shared definitions for the load word-lane extractor.
// Assumes a data word of 16 or 32 bits, built from 8-bit lanes.
package lx_pkg;
    typedef enum logic {
        XOP_BYTE = 1'b0,
        XOP_HALF = 1'b1
    } xop_e;

    // Number of address bits needed to select a byte lane
    function automatic int lane_bits(input int data_w);
        return $clog2(data_w / 8);
    endfunction
endpackage

// File: rtl/lx_addr_align.sv
// Forces the lane-select bits of an address to zero so the bus access is
// word-aligned. Assumes ADDR_W > LANE_BITS.
module lx_addr_align #(
    parameter int ADDR_W    = 32,
    parameter int LANE_BITS = 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    // Pass the upper bits through and clear the lane-select bits
    always_comb begin
        addr_out                  = addr_in;
        addr_out[LANE_BITS-1:0]   = '0;
    end
endmodule

// File: rtl/lx_lane_extract.sv
// Selects one little-endian byte lane, or (for 32-bit words) one half-word,
// and zero-extends it to the full word. Assumes DATA_W is 16 or 32.
module lx_lane_extract
    import lx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 word_in,
    input  logic [lane_bits(DATA_W)-1:0]      lane_sel,
    input  logic                              op_half,
    output logic [DATA_W-1:0]                 result
);
    localparam int LANES = DATA_W / 8;

    logic [7:0]        lane [LANES];
    logic [7:0]        picked;
    logic [DATA_W-1:0] byte_zx;

    // Split the word into byte lanes, lane 0 being the least significant
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_in[8*g +: 8];
    end

    // Choose the addressed byte and zero-extend it
    always_comb begin
        picked  = lane[lane_sel];
        byte_zx = {{(DATA_W-8){1'b0}}, picked};
    end

    if (DATA_W >= 32) begin : g_half
        logic [15:0] half_pick;
        // Half-word chosen by lane_sel[1]; lane_sel[0] plays no part
        always_comb begin
            half_pick = lane_sel[1] ? word_in[31:16] : word_in[15:0];
            result    = (xop_e'(op_half) == XOP_HALF)
                      ? {{(DATA_W-16){1'b0}}, half_pick} : byte_zx;
        end
    end else begin : g_byte_only
        // Narrow word: byte extraction only
        always_comb result = byte_zx;
    end
endmodule

// File: rtl/lx_out_stage.sv
// Optional output register: one flop stage with synchronous active-low
// reset to zero when REG_OUT is 1, a plain wire otherwise.
module lx_out_stage #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        // Capture the value each edge, cleared under reset
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end
endmodule

// File: rtl/lx_load_extract.sv
// Top of the load word-lane extractor: aligns the load address and extracts
// a zero-extended byte or half-word chosen by the address operand's low bits.
// Assumes DATA_W is 16 or 32 and ADDR_W exceeds the lane-select width.
module lx_load_extract
    import lx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              op_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] result
);
    localparam int LB = lane_bits(DATA_W);

    logic [ADDR_W-1:0] aligned_c;
    logic [DATA_W-1:0] extract_c;

    lx_addr_align #(.ADDR_W(ADDR_W), .LANE_BITS(LB)) align_i (
        .addr_in  (addr_in),
        .addr_out (aligned_c)
    );

    lx_lane_extract #(.DATA_W(DATA_W)) extract_i (
        .word_in  (word_in),
        .lane_sel (addr_in[LB-1:0]),
        .op_half  (op_sel),
        .result   (extract_c)
    );

    lx_out_stage #(.W(ADDR_W), .REG_OUT(REG_OUT)) addr_stage_i (
        .clk (clk), .rst_n (rst_n), .d (aligned_c), .q (bus_addr)
    );

    lx_out_stage #(.W(DATA_W), .REG_OUT(REG_OUT)) data_stage_i (
        .clk (clk), .rst_n (rst_n), .d (extract_c), .q (result)
    );
endmodule

// File: rtl/lx_load_extract_chk.sv
// Property checker for lx_load_extract, attached through bind.
// Relates the top-level outputs to the inputs of the previous edge
// (registered option) or of the same edge (combinational option).
module lx_load_extract_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] word_in,
    input logic [ADDR_W-1:0] addr_in,
    input logic              op_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] result
);
    localparam int LB = $clog2(DATA_W / 8);

    logic [DATA_W-1:0] shifted;
    logic              is_byte;
    // Reference lane view and effective operation, built from the inputs
    always_comb begin
        shifted = word_in >> {addr_in[LB-1:0], 3'b000};
        is_byte = (DATA_W < 32) || !op_sel;
    end

    assert_addr_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[LB-1:0] == '0);

    if (REG_OUT) begin : g_seq
        assert_reset_clears_R1: assert property (@(posedge clk)
            !rst_n |=> (result == '0 && bus_addr == '0));

        assert_addr_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> bus_addr[ADDR_W-1:LB] == $past(addr_in[ADDR_W-1:LB]));

        assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(is_byte)) |-> result[7:0] == $past(shifted[7:0]));

        assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(is_byte)) |-> result[DATA_W-1:8] == '0);

        if (DATA_W >= 32) begin : g_half
            assert_half_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(is_byte)) |->
                result == {{(DATA_W-16){1'b0}},
                           ($past(addr_in[1]) ? $past(word_in[31:16]) : $past(word_in[15:0]))});
        end
    end else begin : g_comb
        assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
            is_byte |-> result[7:0] == shifted[7:0]);

        assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
            is_byte |-> result[DATA_W-1:8] == '0);
    end
endmodule

bind lx_load_extract lx_load_extract_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_OUT(REG_OUT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_in  (word_in),
    .addr_in  (addr_in),
    .op_sel   (op_sel),
    .bus_addr (bus_addr),
    .result   (result)
);

// File: tb/lx_load_extract_tb_top.sv
// Self-checking bench for lx_load_extract: vector table, random lane sweep,
// then directed reset, latency and 16-bit variant tests.
module lx_load_extract_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] w32 = '0;
    logic [31:0] a32 = '0;
    logic        op32 = 1'b0;
    logic [31:0] ba32;
    logic [31:0] r32;
    logic [15:0] w16 = '0;
    logic [15:0] a16 = '0;
    logic        op16 = 1'b0;
    logic [15:0] ba16;
    logic [15:0] r16;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    lx_load_extract dut_i (
        .clk(clk), .rst_n(rst_n), .word_in(w32), .addr_in(a32), .op_sel(op32),
        .bus_addr(ba32), .result(r32)
    );

    lx_load_extract #(.DATA_W(16), .ADDR_W(16)) dut16_i (
        .clk(clk), .rst_n(rst_n), .word_in(w16), .addr_in(a16), .op_sel(op16),
        .bus_addr(ba16), .result(r16)
    );

    localparam int NV = 8;
    localparam logic [31:0] V_WORD [NV] = '{32'h48534946, 32'h48534946, 32'h48534946,
        32'h48534946, 32'hA1B2C3D4, 32'hA1B2C3D4, 32'hFFFFFFFF, 32'h80000000};
    localparam logic [31:0] V_ADDR [NV] = '{32'h00001002, 32'h00001000, 32'h00001001,
        32'h00001003, 32'h00000007, 32'h00000005, 32'hFFFFFFFF, 32'hFFFFFFFE};
    localparam logic        V_OP   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] V_RES  [NV] = '{32'h00000053, 32'h00000046, 32'h00000049,
        32'h00000048, 32'h0000A1B2, 32'h0000C3D4, 32'h000000FF, 32'h00008000};
    localparam logic [31:0] V_BA   [NV] = '{32'h00001000, 32'h00001000, 32'h00001000,
        32'h00001000, 32'h00000004, 32'h00000004, 32'hFFFFFFFC, 32'hFFFFFFFC};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model32(input logic [31:0] w, input logic [1:0] lane,
                                           input logic op);
        if (op) return lane[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        return {24'h0, w[8*lane +: 8]};
    endfunction

    task automatic step32(input logic [31:0] w, input logic [31:0] a, input logic op);
        @(negedge clk);
        w32 = w; a32 = a; op32 = op;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #800000;
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset with non-zero inputs
        w32 = 32'hDEADBEEF; a32 = 32'h12345677; op32 = 1'b1;
        w16 = 16'hBEEF; a16 = 16'h1235;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 result under reset", r32, 32'h0);
        check("R1 bus_addr under reset", ba32, 32'h0);
        rst_n = 1'b1;

        // R2..R5: table of fixed vectors
        for (int i = 0; i < NV; i++) begin
            step32(V_WORD[i], V_ADDR[i], V_OP[i]);
            check(V_OP[i] ? "R5 half extract" : "R3/R4 byte extract", r32, V_RES[i]);
            check("R2 aligned address", ba32, V_BA[i]);
        end

        // R3/R4/R5: random sweep over every lane and both operations
        for (int n = 0; n < 16; n++) begin
            logic [31:0] w;
            w = $urandom();
            for (int lane = 0; lane < 4; lane++) begin
                for (int op = 0; op < 2; op++) begin
                    logic [31:0] a;
                    a = {$urandom() & 32'hFFFFFFFC} | lane;
                    step32(w, a, op[0]);
                    check(op ? "R5 sweep" : "R3 sweep", r32, model32(w, lane[1:0], op[0]));
                    check("R2 sweep", ba32, a & 32'hFFFFFFFC);
                end
            end
        end

        // R6: output holds until the next edge
        step32(32'h11223344, 32'h00000002, 1'b0);
        w32 = 32'h55667788; a32 = 32'h00000001; op32 = 1'b0;
        #1;
        check("R6 hold between edges", r32, 32'h00000022);
        @(posedge clk);
        @(negedge clk);
        check("R6 update after edge", r32, 32'h00000077);

        // R7: 16-bit variant, op_sel ignored, bit 0 selects lane
        @(negedge clk);
        w16 = 16'h4946; a16 = 16'h0003; op16 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 16-bit lane 1 op ignored", {16'h0, r16}, 32'h00000049);
        check("R7 16-bit aligned address", {16'h0, ba16}, 32'h00000002);
        w16 = 16'h4946; a16 = 16'h0002; op16 = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 16-bit lane 0", {16'h0, r16}, 32'h00000046);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        w32 = 32'hCAFEF00D; a32 = 32'hFFFFFFFF; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset result", r32, 32'h0);
        check("R1 mid-run reset bus_addr", ba32, 32'h0);

        summary();
        $finish;
    end
endmodule